// File: doc/BRIEF.md
# Local Configuration Space Port

This block lets a CPU reach the controller's own configuration header without mapping that header into its address space. Software first loads a combined port register with a dword-aligned configuration offset, a write flag and four active-low byte enables. It then either writes a data register, which stores the enabled byte lanes into the addressed configuration dword, or reads a data register, which returns the whole addressed dword.

The header held here has a read-only identity dword and a read-only class/revision dword. It also holds a 16-bit command register and a status half-word whose received-master-abort bit is set by a pulse input and cleared by writing one to it. It further holds six base address registers, the last of which is an I/O-space register with bit 0 fixed at one, and a vendor timeout register that packs a retry limit above a ready limit. For a narrow write the caller shifts its data left by 8×n, where n is the starting byte lane, and enables only the lanes that it covers.

Top module: `lcfg_port`

## Requirements
- R1: After reset the port register reads 0, the command/status dword reads 0, BAR0 to BAR4 read 0, BAR5 reads 0x0000_0001 and the timeout dword at offset 0x40 reads 0x0000_80FF.
- R2: A CPU write to offset 0x10 loads the port register, which reads back with the dword offset in bits [7:2], the write flag in bit 16, the active-low byte enables in bits [23:20], and all other bits zero.
- R3: With the write flag set and all four enables zero, a CPU write to offset 0x14 stores the full 32-bit word into the dword the port register addresses.
- R4: During a configuration write, byte lane k (bits 8k+7..8k) changes only when enable bit 20+k of the port register is 0. A write with all enables set to 1 changes nothing.
- R5: A CPU write to offset 0x14 while the write flag (bit 16) is clear leaves all configuration storage unchanged.
- R6: A CPU read of offset 0x18 returns the full addressed configuration dword, whatever the byte enables hold.
- R7: Offset 0x00 reads {device ID, vendor ID} = 0xC0DE_0B1E and offset 0x08 reads {class, revision} = 0x0600_0001. Writes to them have no effect.
- R8: Offsets that hold no register, such as 0x0C, 0x30 and 0x3C, read zero and ignore writes.
- R9: BAR0 to BAR5 sit at offsets 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24. They are fully writable, except that bit 0 of BAR5 always reads 1.
- R10: Status bit 29 of offset 0x04 (received master abort) is set in the cycle after abort_i is high. Writing 1 to it with lane 3 enabled clears it, and writing 0 leaves it set. When abort_i and a clear arrive in the same cycle, the bit stays set.
- R11: Bits [15:0] of offset 0x04 form a writable command register. Status bits other than bit 29 read zero.
- R12: Offset 0x40 holds the retry limit in bits [15:8] and the ready limit in bits [7:0], both writable. Bits [31:16] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | CPU register write strobe |
| reg_addr_i | input | REG_AW | CPU register byte offset (0x10 port, 0x14 write data, 0x18 read data) |
| reg_wdata_i | input | 32 | CPU write data |
| reg_rdata_o | output | 32 | CPU read data, combinational from reg_addr_i |
| abort_i | input | 1 | Pulse reporting an initiator abort |

## Verification
A corrupted port register sends the next data-register access to the wrong dword or the wrong lanes. The bench detects this on the read-back made right after each write, one cycle later. A lane mask that is off by one shows up as a byte that changed or failed to change in the read of 0x18 after a narrow write. An abort flag that ignores set priority or clears on a written zero is visible on the next read of offset 0x04. Because reads are combinational, any stale or misdecoded storage appears in the same cycle the offset is presented.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  localparam int DW_W = 6;  // config dword index width (256-byte header)

  localparam logic [7:0] REG_PORT  = 8'h10;
  localparam logic [7:0] REG_WDATA = 8'h14;
  localparam logic [7:0] REG_RDATA = 8'h18;

  localparam int WFLAG_BIT = 16;
  localparam int BE_LSB    = 20;

  localparam logic [DW_W-1:0] DW_ID    = 6'd0;
  localparam logic [DW_W-1:0] DW_CMDST = 6'd1;
  localparam logic [DW_W-1:0] DW_CLASS = 6'd2;
  localparam logic [DW_W-1:0] DW_BAR0  = 6'd4;
  localparam logic [DW_W-1:0] DW_TMO   = 6'd16;

  localparam int ABORT_BIT = 29;

  typedef struct packed {
    logic [3:0]      be_n;
    logic            wflag;
    logic [DW_W-1:0] dw;
  } port_t;
endpackage

// File: rtl/lcfg_port_regs.sv
module lcfg_port_regs
  import lcfg_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [31:0]       cfg_rdata_i,
  output port_t             port_o,
  output logic              cfg_we_o
);
  port_t       port_q;
  logic        sel_port, sel_wdata, sel_rdata;
  logic [31:0] port_rd;

  assign sel_port  = reg_addr_i == REG_AW'(REG_PORT);
  assign sel_wdata = reg_addr_i == REG_AW'(REG_WDATA);
  assign sel_rdata = reg_addr_i == REG_AW'(REG_RDATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= '0;
    end else if (reg_we_i && sel_port) begin
      port_q.be_n  <= reg_wdata_i[BE_LSB +: 4];
      port_q.wflag <= reg_wdata_i[WFLAG_BIT];
      port_q.dw    <= reg_wdata_i[2 +: DW_W];
    end
  end

  always_comb begin
    port_rd = '0;
    port_rd[BE_LSB +: 4] = port_q.be_n;
    port_rd[WFLAG_BIT]   = port_q.wflag;
    port_rd[2 +: DW_W]   = port_q.dw;
  end

  assign cfg_we_o = reg_we_i && sel_wdata && port_q.wflag;
  assign port_o   = port_q;

  always_comb begin
    if (sel_port)       reg_rdata_o = port_rd;
    else if (sel_rdata) reg_rdata_o = cfg_rdata_i;
    else                reg_rdata_o = '0;
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31:24], reg_wdata_i[19:17], reg_wdata_i[15:8], reg_wdata_i[1:0]};

  // R2: the port register captures exactly the defined fields
  p_port_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && sel_port) |=>
      (port_rd == ($past(reg_wdata_i) & 32'h00F1_00FC)));

  // R5: no config write strobe leaves this block without the write flag
  p_flag_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_o |-> port_rd[WFLAG_BIT]));
endmodule

// File: rtl/lcfg_store.sv
module lcfg_store
  import lcfg_pkg::*;
#(
  parameter int          NUM_BAR   = 6,
  parameter int          IO_BAR    = 5,
  parameter logic [15:0] VEN_ID    = 16'h0B1E,
  parameter logic [15:0] DEV_ID    = 16'hC0DE,
  parameter logic [31:0] CLASS_REV = 32'h0600_0001,
  parameter logic [7:0]  RETRY_RST = 8'h80,
  parameter logic [7:0]  READY_RST = 8'hFF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [DW_W-1:0] cfg_dw_i,
  input  logic [3:0]      cfg_be_n_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic            abort_i,
  output logic [31:0]     cfg_rdata_o
);
  localparam int BIDX_W = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1;

  logic [31:0]              wmask;
  logic [NUM_BAR-1:0][31:0] bar_q;
  logic [15:0]              cmd_q;
  logic [15:0]              tmo_q;
  logic                     abort_q;
  logic                     hit_cmd, hit_tmo, abort_clr;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign wmask[8*k +: 8] = {8{~cfg_be_n_i[k]}};
  end

  for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
    localparam logic [31:0] RST_V = (b == IO_BAR) ? 32'h1 : 32'h0;
    logic hit;
    assign hit = cfg_we_i && (cfg_dw_i == DW_W'(32'(DW_BAR0) + b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bar_q[b] <= RST_V;
      end else if (hit) begin
        bar_q[b] <= (bar_q[b] & ~wmask) | (cfg_wdata_i & wmask) | RST_V;
      end
    end
  end

  assign hit_cmd   = cfg_we_i && (cfg_dw_i == DW_CMDST);
  assign hit_tmo   = cfg_we_i && (cfg_dw_i == DW_TMO);
  assign abort_clr = hit_cmd && wmask[ABORT_BIT] && cfg_wdata_i[ABORT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      tmo_q   <= {RETRY_RST, READY_RST};
      abort_q <= 1'b0;
    end else begin
      if (hit_cmd) cmd_q <= (cmd_q & ~wmask[15:0]) | (cfg_wdata_i[15:0] & wmask[15:0]);
      if (hit_tmo) tmo_q <= (tmo_q & ~wmask[15:0]) | (cfg_wdata_i[15:0] & wmask[15:0]);
      if (abort_i)        abort_q <= 1'b1;  // set beats clear
      else if (abort_clr) abort_q <= 1'b0;
    end
  end

  logic [DW_W-1:0]   bar_off;
  logic [BIDX_W-1:0] bar_idx;
  logic              bar_hit;
  assign bar_off = cfg_dw_i - DW_BAR0;
  assign bar_idx = bar_off[BIDX_W-1:0];
  assign bar_hit = (cfg_dw_i >= DW_BAR0) && (32'(bar_off) < NUM_BAR);

  always_comb begin
    cfg_rdata_o = '0;
    unique case (cfg_dw_i)
      DW_ID:    cfg_rdata_o = {DEV_ID, VEN_ID};
      DW_CLASS: cfg_rdata_o = CLASS_REV;
      DW_TMO:   cfg_rdata_o = {16'h0, tmo_q};
      DW_CMDST: begin
        cfg_rdata_o[15:0]      = cmd_q;
        cfg_rdata_o[ABORT_BIT] = abort_q;
      end
      default:  if (bar_hit) cfg_rdata_o = bar_q[bar_idx];
    endcase
  end

  // R10: a reported abort is latched on the next edge
  p_abort_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> abort_q);

  // R10: a one written to the abort bit clears it when no new abort arrives
  p_abort_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_clr && !abort_i) |=> !abort_q);

  // R4: a write with every lane disabled changes no storage
  p_no_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (&cfg_be_n_i)) |=> ($stable(bar_q) && $stable(cmd_q) && $stable(tmo_q)));

  // R5: storage holds without a gated write strobe
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !abort_i) |=>
      ($stable(bar_q) && $stable(cmd_q) && $stable(tmo_q) && $stable(abort_q)));
endmodule

// File: rtl/lcfg_port.sv
module lcfg_port
  import lcfg_pkg::*;
#(
  parameter int          REG_AW    = 8,
  parameter int          NUM_BAR   = 6,
  parameter int          IO_BAR    = 5,
  parameter logic [15:0] VEN_ID    = 16'h0B1E,
  parameter logic [15:0] DEV_ID    = 16'hC0DE,
  parameter logic [31:0] CLASS_REV = 32'h0600_0001,
  parameter logic [7:0]  RETRY_RST = 8'h80,
  parameter logic [7:0]  READY_RST = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              abort_i
);
  port_t       port;
  logic        cfg_we;
  logic [31:0] cfg_rdata;

  lcfg_port_regs #(.REG_AW(REG_AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cfg_rdata_i (cfg_rdata),
    .port_o      (port),
    .cfg_we_o    (cfg_we)
  );

  lcfg_store #(
    .NUM_BAR   (NUM_BAR),
    .IO_BAR    (IO_BAR),
    .VEN_ID    (VEN_ID),
    .DEV_ID    (DEV_ID),
    .CLASS_REV (CLASS_REV),
    .RETRY_RST (RETRY_RST),
    .READY_RST (READY_RST)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_dw_i    (port.dw),
    .cfg_be_n_i  (port.be_n),
    .cfg_wdata_i (reg_wdata_i),
    .abort_i     (abort_i),
    .cfg_rdata_o (cfg_rdata)
  );
endmodule

// File: tb/lcfg_port_tb.sv
module lcfg_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        abort = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lcfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .abort_i(abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic cfg_wr(input logic [7:0] off, input logic [3:0] be_n, input logic [31:0] d);
    wr(8'h10, {8'h0, be_n, 3'b0, 1'b1, 8'h0, off[7:2], 2'b0});
    wr(8'h14, d);
  endtask

  task automatic cfg_rd(input logic [7:0] off, output logic [31:0] d);
    wr(8'h10, {24'h0, off[7:2], 2'b0});
    rd(8'h18, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h10, v);      chk("R1 port", v, 32'h0);
    cfg_rd(8'h04, v);  chk("R1 cmd/status", v, 32'h0);
    cfg_rd(8'h10, v);  chk("R1 bar0", v, 32'h0);
    cfg_rd(8'h20, v);  chk("R1 bar4", v, 32'h0);
    cfg_rd(8'h24, v);  chk("R1 bar5", v, 32'h1);
    cfg_rd(8'h40, v);  chk("R1 timeout", v, 32'h0000_80FF);
  endtask

  task automatic t_port_readback;
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R2 all ones", v, 32'h00F1_00FC);
    wr(8'h10, 32'h0050_0042); rd(8'h10, v); chk("R2 pattern", v, 32'h0050_0040);
  endtask

  task automatic t_full_write;
    logic [31:0] v;
    cfg_wr(8'h10, 4'h0, 32'hDEAD_BEE0); cfg_rd(8'h10, v); chk("R3 bar0", v, 32'hDEAD_BEE0);
    cfg_wr(8'h1C, 4'h0, 32'h1234_5670); cfg_rd(8'h1C, v); chk("R3 bar3", v, 32'h1234_5670);
    cfg_rd(8'h10, v); chk("R9 bar0 untouched", v, 32'hDEAD_BEE0);
  endtask

  task automatic t_lanes;
    logic [31:0] v;
    cfg_wr(8'h14, 4'h0, 32'h1122_3344);
    cfg_wr(8'h14, 4'b1011, 32'h00AB_0000); cfg_rd(8'h14, v); chk("R4 byte lane2", v, 32'h11AB_3344);
    cfg_wr(8'h14, 4'b1100, 32'h0000_CDEF); cfg_rd(8'h14, v); chk("R4 half lanes0-1", v, 32'h11AB_CDEF);
    cfg_wr(8'h14, 4'hF, 32'hFFFF_FFFF);    cfg_rd(8'h14, v); chk("R4 no lanes", v, 32'h11AB_CDEF);
  endtask

  task automatic t_no_flag;
    logic [31:0] v;
    wr(8'h10, 32'h0000_0014);
    wr(8'h14, 32'hFFFF_FFFF);
    cfg_rd(8'h14, v); chk("R5 no flag", v, 32'h11AB_CDEF);
  endtask

  task automatic t_read_full;
    logic [31:0] v;
    wr(8'h10, 32'h00E0_0014); rd(8'h18, v); chk("R6 ignores enables", v, 32'h11AB_CDEF);
  endtask

  task automatic t_read_only;
    logic [31:0] v;
    cfg_wr(8'h00, 4'h0, 32'hFFFF_FFFF); cfg_rd(8'h00, v); chk("R7 id", v, 32'hC0DE_0B1E);
    cfg_wr(8'h08, 4'h0, 32'h0); cfg_rd(8'h08, v); chk("R7 class", v, 32'h0600_0001);
  endtask

  task automatic t_unimpl;
    logic [31:0] v;
    cfg_wr(8'h30, 4'h0, 32'hA5A5_A5A5); cfg_rd(8'h30, v); chk("R8 0x30", v, 32'h0);
    cfg_wr(8'h0C, 4'h0, 32'hFFFF_FFFF); cfg_rd(8'h0C, v); chk("R8 0x0C", v, 32'h0);
    cfg_rd(8'h3C, v); chk("R8 0x3C", v, 32'h0);
  endtask

  task automatic t_io_bar;
    logic [31:0] v;
    cfg_wr(8'h24, 4'h0, 32'hFFFF_FF00); cfg_rd(8'h24, v); chk("R9 io bar bit0", v, 32'hFFFF_FF01);
    cfg_wr(8'h20, 4'h0, 32'h8765_4321); cfg_rd(8'h20, v); chk("R9 bar4", v, 32'h8765_4321);
  endtask

  task automatic t_cmd;
    logic [31:0] v;
    cfg_wr(8'h04, 4'b1100, 32'h0000_0006); cfg_rd(8'h04, v); chk("R11 cmd", v, 32'h0000_0006);
    cfg_wr(8'h04, 4'h0, 32'hFFFF_FFFF);    cfg_rd(8'h04, v); chk("R11 status ro", v, 32'h0000_FFFF);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
    cfg_rd(8'h04, v); chk("R10 set", v, 32'h2000_FFFF);
    cfg_wr(8'h04, 4'h0, 32'h0000_0000); cfg_rd(8'h04, v); chk("R10 write zero", v, 32'h2000_0000);
    cfg_wr(8'h04, 4'b0111, 32'h2000_0000); cfg_rd(8'h04, v); chk("R10 w1c", v, 32'h0);
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
    wr(8'h10, {8'h0, 4'b0111, 4'b0001, 8'h0, 8'h04});
    @(negedge clk); we = 1'b1; addr = 8'h14; wdata = 32'h2000_0000; abort = 1'b1;
    @(negedge clk); we = 1'b0; abort = 1'b0;
    cfg_rd(8'h04, v); chk("R10 set wins", v, 32'h2000_0000);
  endtask

  task automatic t_timeout;
    logic [31:0] v;
    cfg_wr(8'h40, 4'h0, 32'hFFFF_1234);    cfg_rd(8'h40, v); chk("R12 full", v, 32'h0000_1234);
    cfg_wr(8'h40, 4'b1101, 32'h0000_8000); cfg_rd(8'h40, v); chk("R12 retry lane", v, 32'h0000_8034);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_port_readback();
    t_full_write();
    t_lanes();
    t_no_flag();
    t_read_full();
    t_read_only();
    t_unimpl();
    t_io_bar();
    t_cmd();
    t_abort();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule